// File: doc/BRIEF.md
# Link Pause Capability Resolver

This block settles the flow-control operating mode of an Ethernet port once link bring-up has finished. It takes the pause advertisement bits this port sent and the ones its link partner returned, the mode software asked for, a strict-compliance flag and the negotiated duplex. From these it works out whether pause frames may be sent, received, both or neither. It drives the transmit and receive flow-control enables to match. It also produces the receive-FIFO threshold values that the pause generator uses, and these are forced to zero whenever transmit pause is not part of the resolved mode.

The standard pause table is followed with one deliberate relaxation. When the partner advertises no usable pause capability and the local request includes receiving pause, the block still turns on receive-only pause. The strict flag turns this relaxation off. If negotiation failed and the link was forced, the table is bypassed and the requested mode is applied as is.

Software, or a link state machine, presents all inputs and pulses a resolve strobe. The block captures everything on that edge and updates its outputs on the next edge, together with a one-cycle done pulse.

Top module: `pause_resolve`

## Requirements
- R1: After reset, mode_o is 0, both enables are 0, both threshold outputs are 0, cfg_err_o is 0 and done_o is 0.
- R2: A resolve_i high at rising edge k captures all inputs. Outputs change only at edge k+1, where done_o is high for exactly one cycle. Between done pulses no output changes.
- R3: Mode codes are 0 none, 1 receive only, 2 transmit only, 3 full. Requested codes 0 to 3 mean the same, and 4 means default, which is treated as full. With negotiation complete and both local and partner pause set, the result is 3 if full or default was requested, otherwise 1.
- R4: With negotiation complete, local pause 0, local asym 1, and partner pause and asym both 1, the result is 2.
- R5: With negotiation complete, local pause and asym both 1, partner pause 0 and partner asym 1, the result is 1.
- R6: In every other negotiated combination, the result is 0 if the requested mode is 0 or 2 or strict_i is set, otherwise 1.
- R7: On the negotiated path, full_duplex_i = 0 forces the result to 0 over all other rules.
- R8: tx_fc_en_o is 1 for modes 2 and 3, and rx_fc_en_o is 1 for modes 1 and 3.
- R9: When the resolved mode lacks transmit pause (modes 0 and 1), both thresholds are 0. Otherwise rx_thr_hi_o equals the captured high watermark. rx_thr_lo_o carries the captured low watermark in its low WM_W bits and the XON-enable request in bit WM_W.
- R10: With an_failed_i set (forced link), the requested mode is applied directly, default becomes 3, and advertisement bits and duplex are ignored. This takes priority over an_done_i.
- R11: A requested code of 5, 6 or 7 on a resolving strobe sets cfg_err_o and leaves mode, enables and thresholds unchanged. A later valid resolution clears cfg_err_o.
- R12: A strobe with neither an_done_i nor an_failed_i set still pulses done_o, but mode, enables, thresholds and cfg_err_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| resolve_i | input | 1 | Capture-and-resolve strobe |
| an_done_i | input | 1 | Auto-negotiation reports complete |
| an_failed_i | input | 1 | Negotiation failed, link forced |
| loc_pause_i | input | 1 | Local symmetric pause advertised |
| loc_asym_i | input | 1 | Local asymmetric direction advertised |
| lp_pause_i | input | 1 | Partner symmetric pause advertised |
| lp_asym_i | input | 1 | Partner asymmetric direction advertised |
| req_mode_i | input | 3 | Requested mode (0..3, 4 default, 5..7 invalid) |
| strict_i | input | 1 | Disable receive-only fallback |
| full_duplex_i | input | 1 | Negotiated full duplex |
| xon_en_i | input | 1 | XON sending requested |
| low_wm_i | input | WM_W | Programmed low watermark |
| high_wm_i | input | WM_W | Programmed high watermark |
| mode_o | output | 2 | Resolved flow-control mode |
| tx_fc_en_o | output | 1 | Transmit flow-control enable |
| rx_fc_en_o | output | 1 | Receive flow-control enable |
| rx_thr_lo_o | output | WM_W+1 | Low threshold with XON-enable in the top bit |
| rx_thr_hi_o | output | WM_W | High threshold |
| cfg_err_o | output | 1 | Invalid requested mode seen |
| done_o | output | 1 | One-cycle resolution done pulse |

## Verification
The negotiated path is swept over all sixteen advertisement combinations, against every valid requested code, with and without strict mode, in both duplex settings. This separates the symmetric, the two asymmetric and the fallback rows from one another, shows where strict matters, and shows where half duplex overrides. The forced-link runs pair advertisements that would resolve otherwise with each requested code, which shows that the table is bypassed. Invalid codes, strobes without negotiation status, and watermark and XON patterns in both transmit and non-transmit modes show what is held, what is cleared and which threshold bits move.

// File: rtl/pause_resolve.sv
module pause_resolve #(
  parameter int WM_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            resolve_i,
  input  logic            an_done_i,
  input  logic            an_failed_i,
  input  logic            loc_pause_i,
  input  logic            loc_asym_i,
  input  logic            lp_pause_i,
  input  logic            lp_asym_i,
  input  logic [2:0]      req_mode_i,
  input  logic            strict_i,
  input  logic            full_duplex_i,
  input  logic            xon_en_i,
  input  logic [WM_W-1:0] low_wm_i,
  input  logic [WM_W-1:0] high_wm_i,
  output logic [1:0]      mode_o,
  output logic            tx_fc_en_o,
  output logic            rx_fc_en_o,
  output logic [WM_W:0]   rx_thr_lo_o,
  output logic [WM_W-1:0] rx_thr_hi_o,
  output logic            cfg_err_o,
  output logic            done_o
);
  localparam logic [2:0] REQ_NONE = 3'd0;
  localparam logic [2:0] REQ_TX   = 3'd2;
  localparam logic [2:0] REQ_FULL = 3'd3;
  localparam logic [2:0] REQ_DEF  = 3'd4;
  localparam logic [1:0] M_NONE = 2'd0;
  localparam logic [1:0] M_RX   = 2'd1;
  localparam logic [1:0] M_TX   = 2'd2;
  localparam logic [1:0] M_FULL = 2'd3;

  logic            pend;
  logic            l_done, l_fail, l_lp, l_la, l_pp, l_pa, l_strict, l_fd, l_xon;
  logic [2:0]      l_req;
  logic [WM_W-1:0] l_lw, l_hw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      {l_done, l_fail, l_lp, l_la, l_pp, l_pa, l_strict, l_fd, l_xon} <= '0;
      l_req <= '0;
      l_lw  <= '0;
      l_hw  <= '0;
    end else begin
      pend <= resolve_i;
      if (resolve_i) begin
        l_done   <= an_done_i;
        l_fail   <= an_failed_i;
        l_lp     <= loc_pause_i;
        l_la     <= loc_asym_i;
        l_pp     <= lp_pause_i;
        l_pa     <= lp_asym_i;
        l_strict <= strict_i;
        l_fd     <= full_duplex_i;
        l_xon    <= xon_en_i;
        l_req    <= req_mode_i;
        l_lw     <= low_wm_i;
        l_hw     <= high_wm_i;
      end
    end
  end

  logic [2:0] req_n;
  logic       req_bad;
  logic       do_res;
  logic [1:0] an_mode;
  logic [1:0] res_mode;

  assign req_n   = (l_req == REQ_DEF) ? REQ_FULL : l_req;
  assign req_bad = l_req > REQ_DEF;
  assign do_res  = l_fail | l_done;

  always_comb begin
    if (l_lp && l_pp)
      an_mode = (req_n == REQ_FULL) ? M_FULL : M_RX;
    else if (!l_lp && l_la && l_pp && l_pa)
      an_mode = M_TX;
    else if (l_lp && l_la && !l_pp && l_pa)
      an_mode = M_RX;
    else if (req_n == REQ_NONE || req_n == REQ_TX || l_strict)
      an_mode = M_NONE;
    else
      an_mode = M_RX;
    if (!l_fd)
      an_mode = M_NONE;
  end

  assign res_mode = l_fail ? req_n[1:0] : an_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o      <= M_NONE;
      tx_fc_en_o  <= 1'b0;
      rx_fc_en_o  <= 1'b0;
      rx_thr_lo_o <= '0;
      rx_thr_hi_o <= '0;
      cfg_err_o   <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= pend;
      if (pend && do_res) begin
        if (req_bad) begin
          cfg_err_o <= 1'b1;
        end else begin
          cfg_err_o   <= 1'b0;
          mode_o      <= res_mode;
          tx_fc_en_o  <= res_mode[1];
          rx_fc_en_o  <= res_mode[0];
          rx_thr_lo_o <= res_mode[1] ? {l_xon, l_lw} : '0;
          rx_thr_hi_o <= res_mode[1] ? l_hw : '0;
        end
      end
    end
  end

  p_done_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(resolve_i, 2));

  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(mode_o) && $stable(tx_fc_en_o) && $stable(rx_fc_en_o)
                 && $stable(rx_thr_lo_o) && $stable(rx_thr_hi_o)));

  p_sym_rx_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cfg_err_o && !$past(resolve_i) && l_done && !l_fail && l_fd && l_lp && l_pp)
      |-> rx_fc_en_o);

  p_half_duplex_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cfg_err_o && !$past(resolve_i) && l_done && !l_fail && !l_fd)
      |-> (mode_o == M_NONE));

  p_thr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_fc_en_o |-> (rx_thr_lo_o == '0 && rx_thr_hi_o == '0));

  p_err_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cfg_err_o) |-> ($stable(mode_o) && $stable(rx_thr_lo_o) && $stable(rx_thr_hi_o)));
endmodule

// File: tb/pause_resolve_tb_top.sv
module pause_resolve_tb_top;
  localparam int WM_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic resolve_i = 1'b0, an_done_i = 1'b0, an_failed_i = 1'b0;
  logic loc_pause_i = 1'b0, loc_asym_i = 1'b0, lp_pause_i = 1'b0, lp_asym_i = 1'b0;
  logic [2:0] req_mode_i = '0;
  logic strict_i = 1'b0, full_duplex_i = 1'b0, xon_en_i = 1'b0;
  logic [WM_W-1:0] low_wm_i = '0, high_wm_i = '0;
  logic [1:0] mode_o;
  logic tx_fc_en_o, rx_fc_en_o, cfg_err_o, done_o;
  logic [WM_W:0] rx_thr_lo_o;
  logic [WM_W-1:0] rx_thr_hi_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pause_resolve #(.WM_W(WM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .resolve_i(resolve_i), .an_done_i(an_done_i),
    .an_failed_i(an_failed_i), .loc_pause_i(loc_pause_i), .loc_asym_i(loc_asym_i),
    .lp_pause_i(lp_pause_i), .lp_asym_i(lp_asym_i), .req_mode_i(req_mode_i),
    .strict_i(strict_i), .full_duplex_i(full_duplex_i), .xon_en_i(xon_en_i),
    .low_wm_i(low_wm_i), .high_wm_i(high_wm_i), .mode_o(mode_o),
    .tx_fc_en_o(tx_fc_en_o), .rx_fc_en_o(rx_fc_en_o), .rx_thr_lo_o(rx_thr_lo_o),
    .rx_thr_hi_o(rx_thr_hi_o), .cfg_err_o(cfg_err_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [3:0] adv, input int req,
                                       input logic strict, input logic fd);
    logic lp, la, pp, pa;
    int r;
    logic [1:0] m;
    {lp, la, pp, pa} = adv;
    r = (req == 4) ? 3 : req;
    if (lp && pp) m = (r == 3) ? 2'd3 : 2'd1;
    else if (!lp && la && pp && pa) m = 2'd2;
    else if (lp && la && !pp && pa) m = 2'd1;
    else if (r == 0 || r == 2 || strict) m = 2'd0;
    else m = 2'd1;
    if (!fd) m = 2'd0;
    return m;
  endfunction

  function automatic string rule_tag(input logic [3:0] adv, input logic fd);
    if (!fd) return "R7";
    if (adv[3] && adv[1]) return "R3";
    if (adv == 4'b0111) return "R4";
    if (adv == 4'b1101) return "R5";
    return "R6";
  endfunction

  task automatic strobe();
    @(negedge clk);
    resolve_i = 1'b1;
    @(negedge clk);
    resolve_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_in(input logic done, input logic fail, input logic [3:0] adv,
                        input logic [2:0] req, input logic strict, input logic fd,
                        input logic xon, input logic [WM_W-1:0] lw, input logic [WM_W-1:0] hw);
    an_done_i = done; an_failed_i = fail;
    {loc_pause_i, loc_asym_i, lp_pause_i, lp_asym_i} = adv;
    req_mode_i = req; strict_i = strict; full_duplex_i = fd;
    xon_en_i = xon; low_wm_i = lw; high_wm_i = hw;
  endtask

  task automatic chk_outputs(input string tag, input logic [1:0] m, input logic xon,
                             input logic [WM_W-1:0] lw, input logic [WM_W-1:0] hw);
    chk({tag, " mode"}, 32'(mode_o), 32'(m));
    chk("R8 tx_en", 32'(tx_fc_en_o), 32'(m[1]));
    chk("R8 rx_en", 32'(rx_fc_en_o), 32'(m[0]));
    chk("R9 thr_lo", 32'(rx_thr_lo_o), m[1] ? 32'({xon, lw}) : 32'd0);
    chk("R9 thr_hi", 32'(rx_thr_hi_o), m[1] ? 32'(hw) : 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(mode_o), 0);
    chk("R1 tx_en", 32'(tx_fc_en_o), 0);
    chk("R1 rx_en", 32'(rx_fc_en_o), 0);
    chk("R1 thr_lo", 32'(rx_thr_lo_o), 0);
    chk("R1 thr_hi", 32'(rx_thr_hi_o), 0);
    chk("R1 err", 32'(cfg_err_o), 0);
    chk("R1 done", 32'(done_o), 0);
  endtask

  task automatic t_timing_r2();
    set_in(1, 0, 4'b1010, 3'd3, 0, 1, 1, 16'h0123, 16'h0456);
    @(negedge clk);
    resolve_i = 1'b1;
    @(negedge clk);
    resolve_i = 1'b0;
    chk("R2 no change before update edge", 32'(mode_o), 0);
    chk("R2 done low before update edge", 32'(done_o), 0);
    set_in(1, 0, 4'b0000, 3'd0, 1, 0, 0, 16'h0, 16'h0);
    @(negedge clk);
    chk("R2 done pulse", 32'(done_o), 1);
    chk("R2 captured inputs used", 32'(mode_o), 3);
    @(negedge clk);
    chk("R2 done one cycle", 32'(done_o), 0);
    chk("R2 held after pulse", 32'(mode_o), 3);
  endtask

  task automatic t_sweep();
    for (int req = 0; req <= 4; req++)
      for (int s = 0; s < 2; s++)
        for (int fd = 0; fd < 2; fd++)
          for (int a = 0; a < 16; a++) begin
            logic [1:0] m;
            logic [WM_W-1:0] lw, hw;
            lw = 16'(16'h0100 + a * 7 + req);
            hw = 16'(16'h8000 + a * 13 + s);
            set_in(1, 0, 4'(a), 3'(req), 1'(s), 1'(fd), 1'(a), lw, hw);
            strobe();
            m = model(4'(a), req, 1'(s), 1'(fd));
            chk_outputs(rule_tag(4'(a), 1'(fd)), m, 1'(a), lw, hw);
            chk("R2 done", 32'(done_o), 1);
          end
  endtask

  task automatic t_forced_r10();
    for (int req = 0; req <= 4; req++) begin
      logic [1:0] m;
      m = (req == 4) ? 2'd3 : 2'(req);
      set_in(1, 1, 4'b0000, 3'(req), 1, 0, 1, 16'h0aa5, 16'h5a0f);
      strobe();
      chk_outputs("R10", m, 1, 16'h0aa5, 16'h5a0f);
    end
    set_in(0, 1, 4'b1111, 3'd1, 0, 1, 0, 16'h0011, 16'h0022);
    strobe();
    chk_outputs("R10 forced without an_done", 2'd1, 0, 16'h0011, 16'h0022);
  endtask

  task automatic t_invalid_r11();
    set_in(1, 0, 4'b1010, 3'd3, 0, 1, 0, 16'h1234, 16'h4321);
    strobe();
    chk_outputs("R11 setup", 2'd3, 0, 16'h1234, 16'h4321);
    for (int req = 5; req <= 7; req++) begin
      set_in(1, (req == 6) ? 1'b1 : 1'b0, 4'b0000, 3'(req), 0, 0, 1, 16'h7777, 16'h6666);
      strobe();
      chk("R11 err set", 32'(cfg_err_o), 1);
      chk_outputs("R11 held", 2'd3, 0, 16'h1234, 16'h4321);
    end
    set_in(1, 0, 4'b0000, 3'd0, 0, 1, 0, 16'h0, 16'h0);
    strobe();
    chk("R11 err cleared", 32'(cfg_err_o), 0);
    chk("R11 new mode", 32'(mode_o), 0);
  endtask

  task automatic t_incomplete_r12();
    set_in(1, 0, 4'b0111, 3'd2, 0, 1, 1, 16'h0f0f, 16'hf0f0);
    strobe();
    chk_outputs("R12 setup", 2'd2, 1, 16'h0f0f, 16'hf0f0);
    set_in(0, 0, 4'b1010, 3'd3, 0, 1, 0, 16'h0001, 16'h0002);
    strobe();
    chk("R12 done", 32'(done_o), 1);
    chk_outputs("R12 held", 2'd2, 1, 16'h0f0f, 16'hf0f0);
    set_in(0, 0, 4'b0000, 3'd7, 0, 1, 0, 16'h0, 16'h0);
    strobe();
    chk("R12 err untouched", 32'(cfg_err_o), 0);
    chk_outputs("R12 held again", 2'd2, 1, 16'h0f0f, 16'hf0f0);
  endtask

  task automatic t_thresholds_r9();
    set_in(1, 0, 4'b1111, 3'd4, 0, 1, 0, 16'hffff, 16'hffff);
    strobe();
    chk_outputs("R9 full no xon", 2'd3, 0, 16'hffff, 16'hffff);
    chk("R9 xon bit clear", 32'(rx_thr_lo_o[WM_W]), 0);
    set_in(1, 0, 4'b1111, 3'd4, 0, 1, 1, 16'h0000, 16'h0001);
    strobe();
    chk("R9 xon bit set", 32'(rx_thr_lo_o[WM_W]), 1);
    chk_outputs("R9 full xon", 2'd3, 1, 16'h0000, 16'h0001);
    set_in(1, 0, 4'b1111, 3'd1, 0, 1, 1, 16'hbeef, 16'hcafe);
    strobe();
    chk_outputs("R9 rx only zero thr", 2'd1, 1, 16'hbeef, 16'hcafe);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing_r2();
    t_sweep();
    t_forced_r10();
    t_invalid_r11();
    t_incomplete_r12();
    t_thresholds_r9();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    vectors++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    summary();
  end
endmodule